// File: doc/BRIEF.md
# Modem Control and Status Unit

This block sits beside a serial port and handles the handshake lines around it. A small register bus writes a control byte. That byte drives four output pins: terminal-ready, request-to-send, and two general outputs. It also has a diagnostic loop switch. Four modem input lines pass through a synchroniser: clear-to-send, data-set-ready, ring and carrier detect. A status byte reports their present levels and which lines have changed since software last read it.

Change flags build up between reads, and the read itself clears them. When its enable bit is set, the block raises a modem-status interrupt for as long as any change flag is set. That request is ORed with an interrupt request from the rest of the port. The combined request reaches the outside only while the second general output bit is 1.

In loop mode the four output pins are held low. The control bits then stand in for the modem inputs, so software can test the status path without external wiring.

Top module: `modem_ctl_unit`

## Requirements
- R1: A write to address 0 stores control bits 4:0. Reading address 0 returns them, with bits 7:5 always 0.
- R2: When control bit 4 (loop) is 0, the pins follow the control bits: bit 0 drives `dtrOut`, bit 1 `rtsOut`, bit 2 `out1Out` and bit 3 `out2Out`. When loop is 1, all four pins are 0.
- R3: Status bits 4, 5, 6 and 7 (address 1) give the synchronised levels of CTS, DSR, RI and carrier detect. A change at a pin appears after the second rising clock edge.
- R4: Status bits 0 (CTS), 1 (DSR) and 3 (carrier detect) set one edge after their level changes in either direction. They stay set until the status register is read.
- R5: Status bit 2 sets only when the RI level goes from 1 to 0. A rise of RI leaves it unchanged.
- R6: A read of address 1 with `rdEn` returns the flags as they stood before the read and clears bits 3:0 at that edge. A change detected at the same edge still sets its flag.
- R7: While loop is 1, the levels come from the control bits: CTS from bit 1, DSR from bit 0, RI from bit 2 and carrier detect from bit 3. The external modem inputs are ignored.
- R8: Address 2 holds the interrupt enable, of which only bit 3 is stored; the other bits read 0. `irqModem` is 1 exactly when that bit is 1 and any status bit 3:0 is set.
- R9: `irqOut` equals control bit 3 ANDed with the OR of `irqModem` and `peerIrq`, in loop mode as well.
- R10: After reset, all registers, flags and output pins are 0. Address 3 reads 0, and writes to addresses 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `addr` |
| ctsIn | input | 1 | Clear-to-send level, asynchronous |
| dsrIn | input | 1 | Data-set-ready level, asynchronous |
| riIn | input | 1 | Ring level, asynchronous |
| dcdIn | input | 1 | Carrier detect level, asynchronous |
| peerIrq | input | 1 | Interrupt request from the rest of the port |
| dtrOut | output | 1 | Terminal-ready pin |
| rtsOut | output | 1 | Request-to-send pin |
| out1Out | output | 1 | General output 1 |
| out2Out | output | 1 | General output 2 |
| irqModem | output | 1 | Modem-status interrupt request |
| irqOut | output | 1 | Gated combined interrupt line |

## Verification
The hardest case to reach is a line change that lands at the same clock edge as a status read. If the read is handled wrongly, the clear erases the new flag. The stimulus steps the input at a falling edge and counts the two synchroniser edges. It then raises `rdEn` in exactly the cycle where the new level is visible but its flag is not yet set. The bench expects the old flags in that read and the new flag in the next one. The edge sweeps cover every pair of 4-bit input patterns, which separates the ring trailing-edge rule from the two-way change rule.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int REG_W = 8;

  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  localparam logic [REG_W-1:0] CTL_MASK = 8'h1F;
  localparam int IEN_MODEM = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrIen;
    logic    rdStat;
    regSel_e sel;
  } busStrobe_t;
endpackage

// File: rtl/modem_ctl_sync.sv
module modem_ctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       stageQ[s] <= '0;
      else if (s == 0) stageQ[s] <= asyncIn;
      else             stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/modem_ctl_ctrl.sv
module modem_ctl_ctrl
  import modem_ctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);

  always_comb begin
    if      (addr == A_CTRL) strb.sel = SEL_CTRL;
    else if (addr == A_STAT) strb.sel = SEL_STAT;
    else if (addr == A_IEN)  strb.sel = SEL_IEN;
    else                     strb.sel = SEL_NONE;
    strb.wrCtrl = wrEn && (strb.sel == SEL_CTRL);
    strb.wrIen  = wrEn && (strb.sel == SEL_IEN);
    strb.rdStat = rdEn && (strb.sel == SEL_STAT);
  end
endmodule

// File: rtl/modem_ctl_dp.sv
module modem_ctl_dp
  import modem_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strb,
  input  logic [REG_W-1:0] wrData,
  input  logic [3:0]       extLevel,
  input  logic             peerIrq,
  output logic [REG_W-1:0] rdData,
  output logic             dtrOut,
  output logic             rtsOut,
  output logic             out1Out,
  output logic             out2Out,
  output logic             irqModem,
  output logic             irqOut
);
  localparam int LINES = 4;
  localparam int RI_IDX = 2;

  logic [REG_W-1:0] ctrlQ;
  logic             ienQ;
  logic [LINES-1:0] prevQ, deltaQ, levelNow, changeNow;
  logic             loopOn;

  assign loopOn = ctrlQ[CTL_LOOP];

  // internal routing in loop: CTS<-RTS, DSR<-DTR, RI<-OUT1, DCD<-OUT2
  assign levelNow = loopOn ? {ctrlQ[CTL_OUT2], ctrlQ[CTL_OUT1], ctrlQ[CTL_DTR], ctrlQ[CTL_RTS]}
                           : extLevel;

  for (genvar i = 0; i < LINES; i++) begin : g_edge
    if (i == RI_IDX) begin : g_trail
      assign changeNow[i] = prevQ[i] & ~levelNow[i];
    end else begin : g_both
      assign changeNow[i] = prevQ[i] ^ levelNow[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      ienQ   <= 1'b0;
      prevQ  <= '0;
      deltaQ <= '0;
    end else begin
      prevQ  <= levelNow;
      deltaQ <= (strb.rdStat ? '0 : deltaQ) | changeNow;
      if (strb.wrCtrl) ctrlQ <= wrData & CTL_MASK;
      if (strb.wrIen)  ienQ  <= |(wrData & (REG_W'(1) << IEN_MODEM));
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_CTRL: rdData = ctrlQ;
      SEL_STAT: rdData = {levelNow, deltaQ};
      SEL_IEN:  rdData = REG_W'(ienQ) << IEN_MODEM;
      default:  rdData = '0;
    endcase
  end

  assign {out2Out, out1Out, rtsOut, dtrOut} = loopOn ? 4'b0000 : ctrlQ[3:0];
  assign irqModem = ienQ & (|deltaQ);
  assign irqOut   = ctrlQ[CTL_OUT2] & (irqModem | peerIrq);

  a_r4_delta_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStat |=> ((deltaQ & $past(deltaQ)) == $past(deltaQ)))
    else $error("a_r4_delta_sticky");

  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && (changeNow == '0)) |=> (deltaQ == '0))
    else $error("a_r6_clear_on_read");

  a_r5_ri_trailing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deltaQ[RI_IDX]) |-> ($past(prevQ[RI_IDX]) && !$past(levelNow[RI_IDX])))
    else $error("a_r5_ri_trailing");

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irqModem && !strb.rdStat && !strb.wrIen) |=> irqModem)
    else $error("a_r8_irq_holds");

  a_r7_loop_follow: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && wrData[CTL_LOOP]) |=>
      (levelNow == {$past(wrData[CTL_OUT2]), $past(wrData[CTL_OUT1]),
                    $past(wrData[CTL_DTR]), $past(wrData[CTL_RTS])}))
    else $error("a_r7_loop_follow");
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_ctl_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              ctsIn,
  input  logic              dsrIn,
  input  logic              riIn,
  input  logic              dcdIn,
  input  logic              peerIrq,
  output logic              dtrOut,
  output logic              rtsOut,
  output logic              out1Out,
  output logic              out2Out,
  output logic              irqModem,
  output logic              irqOut
);
  busStrobe_t strb;
  logic [3:0] extLevel;

  modem_ctl_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  modem_ctl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({dcdIn, riIn, dsrIn, ctsIn}),
    .syncOut(extLevel)
  );

  modem_ctl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .extLevel(extLevel), .peerIrq(peerIrq), .rdData(rdData),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .out1Out(out1Out), .out2Out(out2Out),
    .irqModem(irqModem), .irqOut(irqOut)
  );

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqModem || peerIrq))
    else $error("a_r9_irq_source");
endmodule

// File: tb/modem_ctl_unit_tb_top.sv
module modem_ctl_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, wrEn, rdEn, peerIrq;
  logic [1:0] addr;
  logic [7:0] wrData, rdData;
  logic [3:0] modemIn;
  logic dtrOut, rtsOut, out1Out, out2Out, irqModem, irqOut;
  int total = 0, bad = 0;
  bit done = 0;

  modem_ctl_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .ctsIn(modemIn[0]), .dsrIn(modemIn[1]), .riIn(modemIn[2]), .dcdIn(modemIn[3]),
    .peerIrq(peerIrq), .dtrOut(dtrOut), .rtsOut(rtsOut), .out1Out(out1Out),
    .out2Out(out2Out), .irqModem(irqModem), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clearFlags();
    logic [7:0] tmp;
    settle();
    busRead(2'd1, tmp);
  endtask

  function automatic logic [3:0] pins();
    return {out2Out, out1Out, rtsOut, dtrOut};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    modemIn = '0; peerIrq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 pins", {2'b0, irqOut, irqModem, pins()}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      busRead(2'(a), d);
      chk("R10 reg after reset", d, 8'h00);
    end

    // R1 / R2: every control value
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd0, 8'(v));
      busRead(2'd0, d);
      chk("R1 control readback", d, 8'(v) & 8'h1F);
      chk("R2 pins", {4'b0, pins()}, ((v & 16) != 0) ? 8'h00 : 8'(v & 15));
    end
    busWrite(2'd0, 8'h00);
    clearFlags();

    // R8 / R10: enable register and ignored writes
    busWrite(2'd0, 8'h05);
    busWrite(2'd2, 8'hFF);
    busWrite(2'd1, 8'hFF);
    busWrite(2'd3, 8'hFF);
    busRead(2'd0, d); chk("R10 control kept", d, 8'h05);
    busRead(2'd2, d); chk("R8 enable only bit 3", d, 8'h08);
    busRead(2'd3, d); chk("R10 addr 3 reads 0", d, 8'h00);
    busWrite(2'd0, 8'h00);
    clearFlags();

    // R3 / R4 / R5 / R8: every pair of input patterns
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        logic [3:0] pv, nv, dExp;
        pv = 4'(p); nv = 4'(n);
        modemIn = pv;
        clearFlags();
        modemIn = nv;
        settle();
        dExp = {pv[3] ^ nv[3], pv[2] & ~nv[2], pv[1] ^ nv[1], pv[0] ^ nv[0]};
        chk("R8 irqModem", {7'b0, irqModem}, {7'b0, |dExp});
        busRead(2'd1, d);
        chk("R3 R4 R5 status", d, {nv, dExp});
      end
    end
    modemIn = '0;
    clearFlags();

    // R4 accumulation across several changes
    modemIn = 4'b0001; settle();
    modemIn = 4'b0000; settle();
    modemIn = 4'b0010; settle();
    busRead(2'd1, d); chk("R4 accumulate", d, 8'h23);
    busRead(2'd1, d); chk("R6 cleared after read", d, 8'h20);
    modemIn = '0;
    clearFlags();

    // R6 change at the edge of a status read
    @(negedge clk); modemIn = 4'b0001;
    @(negedge clk);
    busRead(2'd1, d); chk("R6 read during change", d, 8'h10);
    busRead(2'd1, d); chk("R6 change survives read", d, 8'h11);
    busRead(2'd1, d); chk("R6 then cleared", d, 8'h10);
    modemIn = '0;
    clearFlags();

    // R7 loop routing and ignored external inputs
    modemIn = 4'b1010;
    for (int v = 0; v < 16; v++) begin
      logic [3:0] cv;
      cv = 4'(v);
      busWrite(2'd0, 8'h10 | 8'(v));
      peek(2'd1, d);
      chk("R7 loop levels", {4'b0, d[7:4]}, {4'b0, cv[3], cv[2], cv[0], cv[1]});
      busRead(2'd1, d);
      modemIn = ~modemIn;
      settle();
      peek(2'd1, d);
      chk("R7 external ignored", d, {cv[3], cv[2], cv[0], cv[1], 4'b0000});
    end
    busWrite(2'd0, 8'h00);
    modemIn = '0;
    clearFlags();

    // R8 / R9 interrupt combinations
    for (int c = 0; c < 16; c++) begin
      logic e, o, pr, dl;
      {e, o, pr, dl} = 4'(c);
      busWrite(2'd2, e ? 8'h08 : 8'h00);
      busWrite(2'd0, o ? 8'h08 : 8'h00);
      clearFlags();
      peerIrq = pr;
      if (dl) begin modemIn = 4'b0001; settle(); end
      @(negedge clk);
      chk("R8 irqModem combo", {7'b0, irqModem}, {7'b0, e & dl});
      chk("R9 irqOut combo", {7'b0, irqOut}, {7'b0, o & ((e & dl) | pr)});
      modemIn = '0; peerIrq = 1'b0;
      clearFlags();
    end

    // R9 gating in loop mode
    busWrite(2'd2, 8'h08);
    busWrite(2'd0, 8'h18);
    settle();
    chk("R2 loop pins quiet", {4'b0, pins()}, 8'h00);
    chk("R9 loop irqOut with OUT2", {7'b0, irqOut}, 8'h01);
    busWrite(2'd0, 8'h10);
    settle();
    chk("R8 irqModem still set", {7'b0, irqModem}, 8'h01);
    chk("R9 loop irqOut without OUT2", {7'b0, irqOut}, 8'h00);
    busWrite(2'd0, 8'h00);
    clearFlags();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule